// File: doc/BRIEF.md
# Transport Bus Move Network

This block is the data interconnect of a small processor whose instructions describe data transfers rather than operations. Each instruction word carries one move slot per transport bus, and every slot is executed in the same cycle. A slot names a source, which is either one of the shared source ports (function unit results or register file read ports) or a short signed constant carried in the source field itself. It also names a destination, which is one of the shared destination ports (function unit operand or trigger inputs, or register file write ports). For every valid slot the network puts the chosen value on its bus and raises the write strobe of the chosen destination. Writing a trigger input is what starts an operation, so the network never sees opcodes. A result can travel straight from one unit's output to another unit's input without passing through a register file.

Each bus reaches only the ports for which a socket link exists. Two parameter masks, one for sources and one for destinations, describe these links. A slot that uses a missing link is reported and has no effect on any destination. When several legal slots aim at the same destination in one cycle, the lowest-numbered bus wins and a per-destination conflict flag is raised. All outputs are registered, so they appear one clock after the instruction and source values are presented.

Top module: `tta_move_net`

## Requirements
- R1: While `rst_n` is low, every output is zero: bus values, write strobes, destination data, error flags and conflict flags.
- R2: A legal move presented in one cycle gives, after the next rising edge, `dst_we_o[d]`=1 and `dst_data_o[d]` equal to the source value sampled at that edge. `dst_data_o[d]` is zero whenever `dst_we_o[d]` is 0.
- R3: Bus b's slot is `instr_i[b*9 +: 9]`. Bits [8:3] are the source field and bits [2:0] are the destination code. When source bit [8] is 1, bits [7:3] are a 5-bit two's-complement constant, which is sign-extended to the data width.
- R4: A slot whose destination code is 0 is a no-op, whatever its source field holds (the all-zero slot included). Its bus reads 0, it writes nothing, and it flags no error.
- R5: When source bit [8] is 0, bits [7:3] index a source port. If that index is at or above the port count, or the port has no link to the slot's bus, the slot raises `move_err_o[b]`, drives 0 on its bus and writes nothing.
- R6: Destination code k (1..7) selects destination port k-1. If that port does not exist or has no link to the slot's bus, the slot raises `move_err_o[b]` and writes nothing.
- R7: Legal slots on different buses that aim at different destinations all write in the same cycle, each with its own value.
- R8: When several legal slots aim at one destination, that destination receives the value from the lowest-numbered bus and `dst_conflict_o[d]` is 1. A slot that is in error takes no part in this arbitration.
- R9: A short constant needs no source link, so it is legal on every bus. Default links are: bus 0 reaches all sources and destinations; bus 1 reaches sources and destinations 0 to 2; bus 2 reaches sources and destinations 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | NUM_BUS*(SRC_F_W+DST_F_W) | One move slot per bus, bus 0 in the low bits |
| src_data_i | input | NUM_SRC*DATA_W | Values of the source ports, port 0 in the low bits |
| bus_data_o | output | NUM_BUS*DATA_W | Registered value carried by each bus |
| dst_we_o | output | NUM_DST | Registered write strobe per destination port |
| dst_data_o | output | NUM_DST*DATA_W | Registered write value per destination port |
| move_err_o | output | NUM_BUS | Registered flag: slot used a missing link or port |
| dst_conflict_o | output | NUM_DST | Registered flag: more than one legal slot aimed at the port |

## Verification
The internal state is a single register stage, so a wrong decode, link check or arbitration decision shows at the ports exactly one clock after the instruction, with no later recovery. A broken link mask appears as a missing or spurious error flag together with a wrong write strobe. A wrong priority order appears as the wrong bus value landing on a contested destination. A bad sign extension corrupts the upper bits of both the bus value and the written value in that same cycle.

// File: rtl/tta_net_pkg.sv
package tta_net_pkg;

    // Default geometry of the transport network
    localparam int unsigned TTA_NUM_BUS  = 3;
    localparam int unsigned TTA_NUM_SRC  = 4;
    localparam int unsigned TTA_NUM_DST  = 4;
    localparam int unsigned TTA_DATA_W   = 16;
    localparam int unsigned TTA_SRC_F_W  = 6;   // MSB: constant flag
    localparam int unsigned TTA_DST_F_W  = 3;   // code 0 = no-op

    // Default socket links, one bit per (bus, port), bus-major
    localparam logic [TTA_NUM_BUS*TTA_NUM_SRC-1:0] TTA_SRC_LINKS = 12'hC7F;
    localparam logic [TTA_NUM_BUS*TTA_NUM_DST-1:0] TTA_DST_LINKS = 12'hC7F;

endpackage

// File: rtl/tta_slot_decode.sv
module tta_slot_decode #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned NUM_DST = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SRC_F_W = 6,
    parameter int unsigned DST_F_W = 3,
    parameter logic [NUM_SRC-1:0] SRC_MASK = '1,
    parameter logic [NUM_DST-1:0] DST_MASK = '1,
    localparam int unsigned SLOT_W = SRC_F_W + DST_F_W,
    localparam int unsigned DIDX_W = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
    input  logic [SLOT_W-1:0]              slot_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] src_i,
    output logic                           req_o,
    output logic [DIDX_W-1:0]              dst_o,
    output logic [DATA_W-1:0]              val_o,
    output logic                           err_o
);
    localparam int unsigned IMM_W = SRC_F_W - 1;

    logic [DST_F_W-1:0] dcode;
    logic [SRC_F_W-1:0] sfield;
    logic               active;
    logic               is_imm;
    logic               src_hit;
    logic               dst_hit;
    logic               legal;
    logic [DATA_W-1:0]  port_val;
    logic [DATA_W-1:0]  imm_val;
    logic [DIDX_W-1:0]  dst_sel;

    always_comb begin
        dcode  = slot_i[DST_F_W-1:0];
        sfield = slot_i[SLOT_W-1:DST_F_W];
        active = (dcode != '0);
        is_imm = sfield[IMM_W];

        // Source port lookup, gated by this bus's links
        src_hit  = 1'b0;
        port_val = '0;
        for (int s = 0; s < int'(NUM_SRC); s++) begin
            if (!is_imm && sfield[IMM_W-1:0] == IMM_W'(s) && SRC_MASK[s]) begin
                src_hit  = 1'b1;
                port_val = src_i[s];
            end
        end

        // Destination lookup, code k maps to port k-1
        dst_hit = 1'b0;
        dst_sel = '0;
        for (int d = 0; d < int'(NUM_DST); d++) begin
            if (dcode == DST_F_W'(d + 1) && DST_MASK[d]) begin
                dst_hit = 1'b1;
                dst_sel = DIDX_W'(d);
            end
        end

        imm_val = {{(DATA_W-IMM_W){sfield[IMM_W-1]}}, sfield[IMM_W-1:0]};
        legal   = active && (is_imm || src_hit) && dst_hit;

        req_o = legal;
        err_o = active && !legal;
        dst_o = dst_sel;
        val_o = legal ? (is_imm ? imm_val : port_val) : '0;
    end
endmodule

// File: rtl/tta_dst_arbiter.sv
module tta_dst_arbiter #(
    parameter int unsigned NUM_BUS = 3,
    parameter int unsigned NUM_DST = 4,
    parameter int unsigned DATA_W  = 16,
    localparam int unsigned DIDX_W = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
    input  logic [NUM_BUS-1:0]             req_i,
    input  logic [NUM_BUS-1:0][DIDX_W-1:0] dst_i,
    input  logic [NUM_BUS-1:0][DATA_W-1:0] val_i,
    output logic [NUM_DST-1:0]             we_o,
    output logic [NUM_DST-1:0][DATA_W-1:0] data_o,
    output logic [NUM_DST-1:0]             conflict_o
);
    for (genvar d = 0; d < NUM_DST; d++) begin : g_port
        always_comb begin
            we_o[d]       = 1'b0;
            data_o[d]     = '0;
            conflict_o[d] = 1'b0;
            // Lowest bus index takes the port; later hits only flag
            for (int b = 0; b < int'(NUM_BUS); b++) begin
                if (req_i[b] && dst_i[b] == DIDX_W'(d)) begin
                    if (!we_o[d]) begin
                        we_o[d]   = 1'b1;
                        data_o[d] = val_i[b];
                    end else begin
                        conflict_o[d] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tta_move_net.sv
module tta_move_net
    import tta_net_pkg::*;
#(
    parameter int unsigned NUM_BUS = TTA_NUM_BUS,
    parameter int unsigned NUM_SRC = TTA_NUM_SRC,
    parameter int unsigned NUM_DST = TTA_NUM_DST,
    parameter int unsigned DATA_W  = TTA_DATA_W,
    parameter int unsigned SRC_F_W = TTA_SRC_F_W,
    parameter int unsigned DST_F_W = TTA_DST_F_W,
    parameter logic [NUM_BUS*NUM_SRC-1:0] SRC_LINKS = TTA_SRC_LINKS,
    parameter logic [NUM_BUS*NUM_DST-1:0] DST_LINKS = TTA_DST_LINKS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BUS*(SRC_F_W+DST_F_W)-1:0] instr_i,
    input  logic [NUM_SRC*DATA_W-1:0]          src_data_i,
    output logic [NUM_BUS*DATA_W-1:0]          bus_data_o,
    output logic [NUM_DST-1:0]                 dst_we_o,
    output logic [NUM_DST*DATA_W-1:0]          dst_data_o,
    output logic [NUM_BUS-1:0]                 move_err_o,
    output logic [NUM_DST-1:0]                 dst_conflict_o
);
    localparam int unsigned SLOT_W = SRC_F_W + DST_F_W;
    localparam int unsigned IMM_W  = SRC_F_W - 1;
    localparam int unsigned DIDX_W = (NUM_DST > 1) ? $clog2(NUM_DST) : 1;

    typedef struct packed {
        logic [NUM_BUS-1:0][DATA_W-1:0] bus;
        logic [NUM_DST-1:0]             we;
        logic [NUM_DST-1:0][DATA_W-1:0] data;
        logic [NUM_BUS-1:0]             err;
        logic [NUM_DST-1:0]             conflict;
    } net_state_t;

    net_state_t st_d, st_q;

    logic [NUM_SRC-1:0][DATA_W-1:0] src_vec;
    logic [NUM_BUS-1:0]             req;
    logic [NUM_BUS-1:0][DIDX_W-1:0] dsel;
    logic [NUM_BUS-1:0][DATA_W-1:0] bval;
    logic [NUM_BUS-1:0]             berr;
    logic [NUM_DST-1:0]             pwe;
    logic [NUM_DST-1:0][DATA_W-1:0] pdata;
    logic [NUM_DST-1:0]             pconf;

    assign src_vec = src_data_i;

    // One decoder per bus, each with its own socket links
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        tta_slot_decode #(
            .NUM_SRC (NUM_SRC),
            .NUM_DST (NUM_DST),
            .DATA_W  (DATA_W),
            .SRC_F_W (SRC_F_W),
            .DST_F_W (DST_F_W),
            .SRC_MASK(SRC_LINKS[b*NUM_SRC +: NUM_SRC]),
            .DST_MASK(DST_LINKS[b*NUM_DST +: NUM_DST])
        ) dec_i (
            .slot_i(instr_i[b*SLOT_W +: SLOT_W]),
            .src_i (src_vec),
            .req_o (req[b]),
            .dst_o (dsel[b]),
            .val_o (bval[b]),
            .err_o (berr[b])
        );
    end

    tta_dst_arbiter #(
        .NUM_BUS(NUM_BUS),
        .NUM_DST(NUM_DST),
        .DATA_W (DATA_W)
    ) arb_i (
        .req_i     (req),
        .dst_i     (dsel),
        .val_i     (bval),
        .we_o      (pwe),
        .data_o    (pdata),
        .conflict_o(pconf)
    );

    always_comb begin
        st_d          = st_q;
        st_d.bus      = bval;
        st_d.we       = pwe;
        st_d.data     = pdata;
        st_d.err      = berr;
        st_d.conflict = pconf;
    end

    // R1: all state clears while reset is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_data_o     = st_q.bus;
    assign dst_we_o       = st_q.we;
    assign dst_data_o     = st_q.data;
    assign move_err_o     = st_q.err;
    assign dst_conflict_o = st_q.conflict;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus_chk
        localparam int unsigned BASE = b * SLOT_W;

        AST_IDLE_SLOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_i[BASE +: DST_F_W] == '0)
            |=> (bus_data_o[b*DATA_W +: DATA_W] == '0 && !move_err_o[b])); // R4

        AST_ERR_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            move_err_o[b] |-> (bus_data_o[b*DATA_W +: DATA_W] == '0)); // R5

        AST_IMM_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_i[BASE +: DST_F_W] != '0 && instr_i[BASE + SLOT_W - 1])
            |=> (move_err_o[b] ||
                 bus_data_o[b*DATA_W +: DATA_W] ==
                 {{(DATA_W-IMM_W){$past(instr_i[BASE + DST_F_W + IMM_W - 1])}},
                  $past(instr_i[BASE + DST_F_W +: IMM_W])})); // R3
    end

    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst_chk
        AST_CONFLICT_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            dst_conflict_o[d] |-> dst_we_o[d]); // R8

        AST_IDLE_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !dst_we_o[d] |-> (dst_data_o[d*DATA_W +: DATA_W] == '0)); // R2
    end

    AST_ERR_BLOCKS_ALL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (&move_err_o) |-> (dst_we_o == '0)); // R6

endmodule

// File: tb/tta_move_net_tb_top.sv
module tta_move_net_tb_top;

    logic        clk;
    logic        rst_n;
    logic [26:0] instr;
    logic [63:0] src;
    logic [47:0] bus;
    logic [3:0]  we;
    logic [63:0] data;
    logic [2:0]  err;
    logic [3:0]  conf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    tta_move_net dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr),
        .src_data_i    (src),
        .bus_data_o    (bus),
        .dst_we_o      (we),
        .dst_data_o    (data),
        .move_err_o    (err),
        .dst_conflict_o(conf)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Source field codes: bit 5 = constant flag, bits 4:0 = index/value
    localparam logic [5:0] SP0 = 6'h00, SP1 = 6'h01, SP2 = 6'h02, SP3 = 6'h03, SP5 = 6'h05;
    localparam logic [5:0] K_M1 = 6'h3F, K_15 = 6'h2F, K_M16 = 6'h30, K_3 = 6'h23;
    localparam logic [8:0] NOP = 9'h000;
    localparam logic [63:0] SRC_DEF = {16'h4444, 16'h3333, 16'h2222, 16'h1111};

    typedef struct packed {
        logic [26:0] instr;
        logic [3:0]  we;
        logic [63:0] data;
        logic [2:0]  err;
        logic [3:0]  cf;
        logic [47:0] bus;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R4: all-zero word
        '{27'h0, 4'b0000, 64'h0, 3'b000, 4'b0000, 48'h0, 4'd4},
        // R2: bus0 port1 -> dst0
        '{{NOP, NOP, {SP1, 3'd1}}, 4'b0001, {48'h0, 16'h2222}, 3'b000, 4'b0000,
          {32'h0, 16'h2222}, 4'd2},
        // R7: three parallel moves
        '{{{SP3, 3'd3}, {SP2, 3'd2}, {SP0, 3'd4}}, 4'b1110,
          {16'h1111, 16'h4444, 16'h3333, 16'h0000}, 3'b000, 4'b0000,
          {16'h4444, 16'h3333, 16'h1111}, 4'd7},
        // R3: sign-extended constants
        '{{{K_M16, 3'd4}, {K_15, 3'd2}, {K_M1, 3'd1}}, 4'b1011,
          {16'hFFF0, 16'h0000, 16'h000F, 16'hFFFF}, 3'b000, 4'b0000,
          {16'hFFF0, 16'h000F, 16'hFFFF}, 4'd3},
        // R5: unlinked sources on bus1 and bus2
        '{{{SP0, 3'd3}, {SP3, 3'd1}, {SP2, 3'd3}}, 4'b0100,
          {16'h0, 16'h3333, 32'h0}, 3'b110, 4'b0000,
          {32'h0, 16'h3333}, 4'd5},
        // R6: unlinked destinations, plus R5 out-of-range source on bus0
        '{{{SP2, 3'd1}, {SP0, 3'd4}, {SP5, 3'd1}}, 4'b0000, 64'h0, 3'b111, 4'b0000,
          48'h0, 4'd6},
        // R8: three buses on dst2, bus0 wins
        '{{{SP3, 3'd3}, {SP1, 3'd3}, {SP0, 3'd3}}, 4'b0100,
          {16'h0, 16'h1111, 32'h0}, 3'b000, 4'b0100,
          {16'h4444, 16'h2222, 16'h1111}, 4'd8},
        // R8: bus0 idle, bus1 wins over bus2
        '{{{SP2, 3'd3}, {K_3, 3'd3}, NOP}, 4'b0100,
          {16'h0, 16'h0003, 32'h0}, 3'b000, 4'b0100,
          {16'h3333, 16'h0003, 16'h0000}, 4'd8},
        // R4: code 0 with non-zero source fields
        '{{NOP, {K_M1, 3'd0}, {SP3, 3'd0}}, 4'b0000, 64'h0, 3'b000, 4'b0000,
          48'h0, 4'd4},
        // R5/R8: erroring slot does not contest dst1
        '{{NOP, {SP3, 3'd2}, {SP3, 3'd2}}, 4'b0010,
          {32'h0, 16'h4444, 16'h0}, 3'b010, 4'b0000,
          {32'h0, 16'h4444}, 4'd5},
        // R9: constant on bus1 into dst0
        '{{NOP, {K_15, 3'd1}, NOP}, 4'b0001, {48'h0, 16'h000F}, 3'b000, 4'b0000,
          {16'h0, 16'h000F, 16'h0}, 4'd9}
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        instr = '0;
        src   = SRC_DEF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bus", {16'h0, bus}, 64'h0);
        chk("R1 we/err/conf", {53'h0, we, err, conf}, 64'h0);
        chk("R1 data", data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            instr = VECS[i].instr;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d we", VECS[i].req, i), {60'h0, we}, {60'h0, VECS[i].we});
            chk($sformatf("R%0d vec%0d data", VECS[i].req, i), data, VECS[i].data);
            chk($sformatf("R%0d vec%0d err", VECS[i].req, i), {61'h0, err}, {61'h0, VECS[i].err});
            chk($sformatf("R%0d vec%0d conflict", VECS[i].req, i), {60'h0, conf}, {60'h0, VECS[i].cf});
            chk($sformatf("R%0d vec%0d bus", VECS[i].req, i), {16'h0, bus}, {16'h0, VECS[i].bus});
        end

        // R2: one-cycle latency, output unchanged before the edge
        instr = '0;
        @(negedge clk);
        instr = {NOP, NOP, {SP2, 3'd4}};
        #5;
        chk("R2 before edge we", {60'h0, we}, 64'h0);
        @(negedge clk);
        chk("R2 after edge we", {60'h0, we}, 64'h8);
        chk("R2 after edge data", data, {16'h3333, 48'h0});
        // R2: source sampled at each edge
        src[47:32] = 16'hABCD;
        @(negedge clk);
        chk("R2 new source data", data, {16'hABCD, 48'h0});

        // R1: reset clears live outputs
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run we", {60'h0, we}, 64'h0);
        chk("R1 mid-run bus", {16'h0, bus}, 64'h0);
        @(negedge clk);
        summary();
    end

endmodule